// File: doc/BRIEF.md
# Timer Status and Decrementer Unit

This block keeps a 32-bit timer control word, a timer status word, a down-counting decrementer and a reload value. Three level interrupt outputs come from it: decrementer, fixed-interval and watchdog. Each output is high while its status bit and the matching enable bit in the control word are both set. Software clears a status bit by writing a 1 to that bit position.

The decrementer counts down by one on each cycle that the count-enable `tick` is high. When the count passes from 1 to 0, the unit sets the decrementer status bit. If auto-reload is enabled at that point, the count is loaded from the reload register. Otherwise it stops at zero. An external periodic-event generator sends single-cycle pulses on `fit_evt` and `wdt_evt`, and these set the fixed-interval and watchdog status bits.

The decrementer is controlled by a two-state machine:
- `DEC_HALT` means the count is zero and ticks are ignored.
- `DEC_RUN` means the count is non-zero and each tick decrements it.

The transitions are:
- *load-nonzero*: a write of a non-zero value moves either state to `DEC_RUN`.
- *load-zero*: a write of zero moves either state to `DEC_HALT`.
- *expire-reload*: a tick at count 1, with auto-reload on and a non-zero reload value, stays in `DEC_RUN`.
- *expire-stop*: a tick at count 1 in any other case moves to `DEC_HALT`.
- *count*: a tick at a count above 1 stays in `DEC_RUN`.

Top module: `tsd_top`

## Requirements
- R1: Registers are selected by `addr`: 0 is control, 1 is status, 2 is decrementer and 3 is reload. A write takes effect at the clock edge where `wr_en` is high. `rdata` shows the addressed register combinationally. Status reads return only bits 30, 27 and 26, and all other status bits read 0.
- R2: All 32 bits written to the control register are stored and read back unchanged. The enables are at fixed positions: watchdog interrupt enable at bit 27, decrementer interrupt enable at bit 26, fixed-interval interrupt enable at bit 23 and auto-reload enable at bit 22.
- R3: A write to the status register clears every status bit whose written data bit is 1. Bits written with 0 are unchanged.
- R4: If a status clear and a set event hit the same bit in the same cycle, the bit ends up set.
- R5: A `fit_evt` pulse sets status bit 26, and a `wdt_evt` pulse sets status bit 30.
- R6: `irq_dec` equals status bit 27 AND control bit 26. `irq_fit` equals status bit 26 AND control bit 23. `irq_wdt` equals status bit 30 AND control bit 27. Each output follows in the cycle right after the register change.
- R7: Each cycle with `tick` high and a non-zero count decrements the count by one. A decrementer write in the same cycle takes priority over the tick.
- R8: A tick that moves the count from 1 to 0 sets status bit 27.
- R9: At expiry with auto-reload enabled, the count is loaded from the reload register, and further expiries follow.
- R10: With auto-reload disabled, the count stays at 0 after expiry and raises no further expiry.
- R11: Writing the decrementer loads the written value and leaves the status bits unchanged.
- R12: A synchronous active-low reset clears control, status, decrementer and reload, so all interrupts are low.
- R13: While `tick` is low and no write occurs, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| tick | input | 1 | Decrementer count enable |
| fit_evt | input | 1 | Fixed-interval event pulse |
| wdt_evt | input | 1 | Watchdog event pulse |
| irq_dec | output | 1 | Decrementer interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |
| irq_wdt | output | 1 | Watchdog interrupt |

## Verification
The properties assume that `addr` is always a defined two-bit value whenever `wr_en` is high. They also assume that the event inputs are synchronous to `clk` and free of X after reset. The interrupt-follow property additionally takes for granted that the control word is not rewritten in the same cycle as the event it watches. The stimulus drives every input from the falling edge, keeps `addr` defined at all times, and holds the events low except for deliberate single-cycle pulses. One pulse is aimed on purpose at the same cycle as a status clear, to exercise the collision case.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
    localparam int REG_W = 32;

    // control word bit positions
    localparam int C_WDT_IE = 27;
    localparam int C_DEC_IE = 26;
    localparam int C_FIT_IE = 23;
    localparam int C_AUTO   = 22;

    // status word bit positions
    localparam int S_WDT = 30;
    localparam int S_DEC = 27;
    localparam int S_FIT = 26;

    localparam logic [REG_W-1:0] STAT_IMPL =
        (REG_W'(1) << S_WDT) | (REG_W'(1) << S_DEC) | (REG_W'(1) << S_FIT);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DEC  = 2'd2,
        SEL_RLD  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DEC_HALT = 1'b0,
        DEC_RUN  = 1'b1
    } dec_state_e;
endpackage

// File: rtl/tsd_decr.sv
module tsd_decr
    import tsd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             auto_rld,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dec_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state and count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state, next count and expiry strobe
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (load_en) begin
            cnt_d   = load_val;
            state_d = (load_val != '0) ? DEC_RUN : DEC_HALT;
        end else begin
            unique case (state_q)
                DEC_HALT: begin
                    state_d = DEC_HALT;
                end
                DEC_RUN: begin
                    if (tick) begin
                        if (cnt_q == ONE) begin
                            expire  = 1'b1;
                            cnt_d   = auto_rld ? rld_val : '0;
                            state_d = (auto_rld && rld_val != '0) ? DEC_RUN : DEC_HALT;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: state_d = DEC_HALT;
            endcase
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tsd_status.sv
module tsd_status
    import tsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [REG_W-1:0] set_mask,
    output logic [REG_W-1:0] stat
);
    logic [REG_W-1:0] stat_q, keep;

    always_comb begin
        keep = clr_en ? (stat_q & ~clr_mask) : stat_q;
    end

    // set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (keep | set_mask) & STAT_IMPL;
    end

    assign stat = stat_q;
endmodule

// File: rtl/tsd_irq.sv
module tsd_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] st_bits,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign irq[i] = st_bits[i] & en_bits[i];
    end
endmodule

// File: rtl/tsd_top.sv
module tsd_top
    import tsd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        tick,
    input  logic        fit_evt,
    input  logic        wdt_evt,
    output logic        irq_dec,
    output logic        irq_fit,
    output logic        irq_wdt
);
    logic [REG_W-1:0] ctrl_q, stat_q, set_mask;
    logic [CNT_W-1:0] dec_q, rld_q;
    logic             dec_expire;
    logic [2:0]       irq_v;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rld_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) ctrl_q <= wdata;
            if (sel == SEL_RLD)  rld_q  <= wdata[CNT_W-1:0];
        end
    end

    tsd_decr #(.CNT_W(CNT_W)) u_decr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (wr_en && sel == SEL_DEC),
        .load_val (wdata[CNT_W-1:0]),
        .tick     (tick),
        .auto_rld (ctrl_q[C_AUTO]),
        .rld_val  (rld_q),
        .cnt      (dec_q),
        .expire   (dec_expire)
    );

    always_comb begin
        set_mask = '0;
        set_mask[S_FIT] = fit_evt;
        set_mask[S_WDT] = wdt_evt;
        set_mask[S_DEC] = dec_expire;
    end

    tsd_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_en && sel == SEL_STAT),
        .clr_mask (wdata),
        .set_mask (set_mask),
        .stat     (stat_q)
    );

    tsd_irq #(.N(3)) u_irq (
        .st_bits ({stat_q[S_WDT], stat_q[S_FIT], stat_q[S_DEC]}),
        .en_bits ({ctrl_q[C_WDT_IE], ctrl_q[C_FIT_IE], ctrl_q[C_DEC_IE]}),
        .irq     (irq_v)
    );

    assign irq_dec = irq_v[0];
    assign irq_fit = irq_v[1];
    assign irq_wdt = irq_v[2];

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl_q;
            SEL_STAT: rdata = stat_q;
            SEL_DEC:  rdata = 32'(dec_q);
            SEL_RLD:  rdata = 32'(rld_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsd_chk.sv
module tsd_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic             tick,
    input logic             fit_evt,
    input logic             wdt_evt,
    input logic             irq_dec,
    input logic             irq_fit,
    input logic             irq_wdt,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      stat_q,
    input logic [CNT_W-1:0] dec_q,
    input logic [CNT_W-1:0] rld_q
);
    logic wr_ctrl, wr_stat, wr_dec;
    assign wr_ctrl = wr_en && addr == 2'd0;
    assign wr_stat = wr_en && addr == 2'd1;
    assign wr_dec  = wr_en && addr == 2'd2;

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && wdata[26] && !fit_evt |=> !stat_q[26]);

    assert_setwins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && wdata[30] && wdt_evt |=> stat_q[30]);

    assert_fitset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fit_evt |=> stat_q[26]);

    assert_irqfollow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fit_evt && ctrl_q[23] && !wr_ctrl |=> irq_fit);

    assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_dec && dec_q > CNT_W'(1) |=> dec_q == $past(dec_q) - CNT_W'(1));

    assert_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_dec && dec_q == CNT_W'(1) |=> stat_q[27]);

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_dec && dec_q == CNT_W'(1) && ctrl_q[22] |=> dec_q == $past(rld_q));

    assert_stayzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q == '0 && !wr_dec |=> dec_q == '0);

    assert_loadquiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dec && !fit_evt && !wdt_evt |=> stat_q == $past(stat_q));

    assert_reset_R12: assert property (@(posedge clk)
        !rst_n |=> ctrl_q == '0 && stat_q == '0 && !irq_dec && !irq_fit && !irq_wdt);

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_dec |=> $stable(dec_q));
endmodule

bind tsd_top tsd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tick    (tick),
    .fit_evt (fit_evt),
    .wdt_evt (wdt_evt),
    .irq_dec (irq_dec),
    .irq_fit (irq_fit),
    .irq_wdt (irq_wdt),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q),
    .dec_q   (dec_q),
    .rld_q   (rld_q)
);

// File: tb/sim_tsd_top.sv
module sim_tsd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        fit_evt = 1'b0;
    logic        wdt_evt = 1'b0;
    logic        irq_dec, irq_fit, irq_wdt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tsd_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .fit_evt(fit_evt), .wdt_evt(wdt_evt),
        .irq_dec(irq_dec), .irq_fit(irq_fit), .irq_wdt(irq_wdt)
    );

    // behavioural reference model
    logic [31:0] m_ctrl = '0, m_stat = '0, m_dec = '0, m_rld = '0;

    always @(posedge clk) begin
        logic [31:0] old_ctrl, old_rld, clr, set;
        old_ctrl = m_ctrl;
        old_rld  = m_rld;
        if (!rst_n) begin
            m_ctrl = 0; m_stat = 0; m_dec = 0; m_rld = 0;
        end else begin
            clr = 0;
            set = 0;
            if (fit_evt) set = set | 32'h0400_0000;
            if (wdt_evt) set = set | 32'h4000_0000;
            if (tick && !(wr_en && addr == 2) && m_dec != 0) begin
                if (m_dec == 1) begin
                    set   = set | 32'h0800_0000;
                    m_dec = old_ctrl[22] ? old_rld : 0;
                end else begin
                    m_dec = m_dec - 1;
                end
            end
            if (wr_en) begin
                case (addr)
                    2'd0: m_ctrl = wdata;
                    2'd1: clr = wdata;
                    2'd2: m_dec = wdata;
                    default: m_rld = wdata;
                endcase
            end
            m_stat = ((m_stat & ~clr) | set) & 32'h4C00_0000;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // interrupts compared to the model every cycle (R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 irq_dec", {31'd0, irq_dec}, {31'd0, m_stat[27] & m_ctrl[26]});
            check("R6 irq_fit", {31'd0, irq_fit}, {31'd0, m_stat[26] & m_ctrl[23]});
            check("R6 irq_wdt", {31'd0, irq_wdt}, {31'd0, m_stat[30] & m_ctrl[27]});
        end
    end

    function automatic logic [31:0] model_reg(logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_stat;
            2'd2: return m_dec;
            default: return m_rld;
        endcase
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
        check({tag, " model"}, rdata, model_reg(a));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(0, 0, "R12 ctrl reset");
        rd(1, 0, "R12 stat reset");
        rd(2, 0, "R12 dec reset");
        rd(3, 0, "R12 rld reset");

        wr(0, 32'hA5C0_1234);
        rd(0, 32'hA5C0_1234, "R2 ctrl readback");
        wr(0, 32'h0);

        // fixed-interval event, enable afterwards (R5, R6)
        fit_evt = 1'b1; @(negedge clk); fit_evt = 1'b0;
        rd(1, 32'h0400_0000, "R5 fit status");
        check("R6 fit masked", {31'd0, irq_fit}, 0);
        wr(0, 32'h0080_0000);
        check("R6 fit enabled", {31'd0, irq_fit}, 1);
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
        rd(1, 32'h4400_0000, "R5 wdt status R1");
        wr(0, 32'h0880_0000);
        check("R6 wdt enabled", {31'd0, irq_wdt}, 1);

        // write-one-to-clear (R3)
        wr(1, 32'h0400_0000);
        rd(1, 32'h4000_0000, "R3 clear fit only");
        check("R3 irq_fit low", {31'd0, irq_fit}, 0);

        // clear and set collide (R4)
        wdt_evt = 1'b1; wr(1, 32'h4000_0000); wdt_evt = 1'b0;
        rd(1, 32'h4000_0000, "R4 set wins");
        wr(1, 32'hFFFF_FFFF);
        rd(1, 0, "R3 clear all");

        // direct load (R11), counting (R7), hold (R13)
        wdt_evt = 1'b1; @(negedge clk); wdt_evt = 1'b0;
        wr(2, 5);
        rd(2, 5, "R11 dec load");
        rd(1, 32'h4000_0000, "R11 status untouched");
        wr(1, 32'hFFFF_FFFF);
        ticks(3);
        rd(2, 2, "R7 count down");
        repeat (3) @(negedge clk);
        rd(2, 2, "R13 hold");
        tick = 1'b1; wr(2, 9); tick = 1'b0;
        rd(2, 9, "R7 write beats tick");

        // expiry without reload (R8, R10)
        wr(0, 32'h0400_0000);
        wr(2, 2);
        ticks(2);
        rd(2, 0, "R8 reached zero");
        rd(1, 32'h0800_0000, "R8 dec status");
        check("R8 irq_dec", {31'd0, irq_dec}, 1);
        wr(1, 32'h0800_0000);
        ticks(5);
        rd(2, 0, "R10 stays zero");
        rd(1, 0, "R10 no new expiry");

        // expiry with reload (R9)
        wr(0, 32'h0440_0000);
        wr(3, 4);
        wr(2, 1);
        ticks(1);
        rd(2, 4, "R9 reloaded");
        rd(1, 32'h0800_0000, "R9 status");
        wr(1, 32'h0800_0000);
        ticks(4);
        rd(2, 4, "R9 second reload");
        rd(1, 32'h0800_0000, "R9 second expiry");
        ticks(2);
        rd(2, 2, "R7 after reload");

        // reset mid-run (R12)
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(0, 0, "R12 ctrl cleared");
        rd(1, 0, "R12 stat cleared");
        rd(2, 0, "R12 dec cleared");
        rd(3, 0, "R12 rld cleared");
        check("R12 irqs low", {29'd0, irq_dec, irq_fit, irq_wdt}, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule